// File: doc/BRIEF.md
# Dual-Port Synchronous Block Memory

This block is a synchronous memory with two fully independent ports, A and B. Each port has its own clock, clock enable, write enable, address, write data, 3-bit chip select, local output reset and read data output. An active-low global reset clears the outputs of both ports. Every port first captures its address, data and control inputs in an entry register. The memory access happens on the following edge of that port's clock. A parameter can add a second register on the read data path.

Each port takes a write-behaviour parameter. In normal mode the output keeps its value during a write. In write-through mode the output shows the word being written. In read-before-write mode the output shows the word that the write replaces. A port only acts when its clock enable is high and its chip-select input equals a per-port constant, so several instances can share address and data lines to build a deeper memory. A parameter makes the output reset act either on the clock edge or immediately. Resets never touch the stored words.

Top module: `bram2p`

## Requirements
- R1: After the global reset `gRstN` is driven low, `doutA` and `doutB` read all zeros.
- R2: A port samples its inputs on a rising edge k of its clock. The read result appears on its output after edge k+1 when its output register parameter is 0, and after edge k+2 when it is 1.
- R3: In normal mode (`WM_NORMAL`), a write access leaves that port's output unchanged.
- R4: In write-through mode (`WM_THROUGH`), a write access drives the written data onto that port's output.
- R5: In read-before-write mode (`WM_BEFORE`), a write access drives the word previously stored at the address onto that port's output.
- R6: With `ASYNC_RST` = 1, an output reset clears the output at once, without waiting for a clock edge. With `ASYNC_RST` = 0, it clears the output on the next rising edge of the port's clock.
- R7: A port accesses the memory only when its clock enable is 1 and its chip-select input equals its `CS_A`/`CS_B` parameter. Otherwise it writes nothing and its output holds.
- R8: When both ports write the same address in the same cycle, the word from port A is stored.
- R9: When one port reads an address that the other port writes in the same cycle, the read returns the old word.
- R10: The local reset `rstA` or `rstB` clears only its own port's output and leaves the other port's output unchanged.
- R11: Neither local nor global reset alters the stored words.
- R12: All 2^ADDR_W addresses, from 0 to the top one, store the full DATA_W-bit word (default 18 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gRstN | input | 1 | Global active-low reset of both port outputs |
| clkA | input | 1 | Port A clock |
| ceA | input | 1 | Port A clock enable |
| weA | input | 1 | Port A write enable |
| csA | input | 3 | Port A chip select |
| addrA | input | ADDR_W | Port A word address |
| dinA | input | DATA_W | Port A write data |
| rstA | input | 1 | Port A local output reset, active high |
| doutA | output | DATA_W | Port A read data |
| clkB | input | 1 | Port B clock |
| ceB | input | 1 | Port B clock enable |
| weB | input | 1 | Port B write enable |
| csB | input | 3 | Port B chip select |
| addrB | input | ADDR_W | Port B word address |
| dinB | input | DATA_W | Port B write data |
| rstB | input | 1 | Port B local output reset, active high |
| doutB | output | DATA_W | Port B read data |

## Verification
The bench runs two instances side by side. One uses write-through on A and read-before-write with an output register on B, with synchronous reset. The other uses normal mode and asynchronous reset. The same write therefore separates the three output behaviours, and a reset pulse placed between edges separates the two reset styles.

Several access patterns are applied:
- Reads one cycle early pin down the latency of each port.
- Writes with a wrong chip select or with the enable low show that a blocked access changes neither memory nor output.
- Simultaneous same-address writes and same-address write/read pairs tell port priority apart from old-data return.
- Reads after both kinds of reset show that the stored words survive.

// File: rtl/bram2p_pkg.sv
package bram2p_pkg;

  typedef enum logic [1:0] {
    WM_NORMAL  = 2'd0,
    WM_THROUGH = 2'd1,
    WM_BEFORE  = 2'd2
  } writeMode_e;

  // strobes handed from a port's control to the datapath
  typedef struct packed {
    logic acc;   // registered access (enable and select matched)
    logic wr;    // registered write access
  } portStrobe_t;

endpackage

// File: rtl/bram2p_ctrl.sv
module bram2p_ctrl
  import bram2p_pkg::*;
#(
  parameter logic [2:0] CS_SEL = 3'd0
) (
  input  logic        clk,
  input  logic        gRstN,
  input  logic        ce,
  input  logic        we,
  input  logic [2:0]  cs,
  output portStrobe_t stb
);

  logic selHit;
  portStrobe_t stbNext;

  always_comb begin
    selHit      = ce && (cs == CS_SEL);
    stbNext.acc = selHit;
    stbNext.wr  = selHit && we;
  end

  // entry register for the control inputs
  always_ff @(posedge clk or negedge gRstN) begin
    if (!gRstN) stb <= '0;
    else        stb <= stbNext;
  end

endmodule

// File: rtl/bram2p_outstage.sv
module bram2p_outstage
  import bram2p_pkg::*;
#(
  parameter int         DATA_W    = 18,
  parameter writeMode_e MODE      = WM_NORMAL,
  parameter bit         OUTREG    = 1'b0,
  parameter bit         ASYNC_RST = 1'b0
) (
  input  logic              clk,
  input  logic              gRstN,
  input  logic              rstLocal,
  input  portStrobe_t       stb,
  input  logic [DATA_W-1:0] dinReg,
  input  logic [DATA_W-1:0] readWord,
  output logic [DATA_W-1:0] dout
);

  logic              rstAny;
  logic [DATA_W-1:0] latchNext;
  logic [DATA_W-1:0] outLatch;

  assign rstAny = rstLocal || !gRstN;

  always_comb begin
    latchNext = outLatch;
    if (stb.acc) begin
      if (!stb.wr) begin
        latchNext = readWord;
      end else begin
        case (MODE)
          WM_THROUGH: latchNext = dinReg;
          WM_BEFORE:  latchNext = readWord;
          default:    latchNext = outLatch;
        endcase
      end
    end
  end

  generate
    if (ASYNC_RST) begin : g_asyncLatch
      always_ff @(posedge clk or posedge rstAny) begin
        if (rstAny) outLatch <= '0;
        else        outLatch <= latchNext;
      end
    end else begin : g_syncLatch
      always_ff @(posedge clk) begin
        if (rstAny) outLatch <= '0;
        else        outLatch <= latchNext;
      end
    end

    if (OUTREG) begin : g_outReg
      logic [DATA_W-1:0] pipeReg;
      if (ASYNC_RST) begin : g_asyncPipe
        always_ff @(posedge clk or posedge rstAny) begin
          if (rstAny) pipeReg <= '0;
          else        pipeReg <= outLatch;
        end
      end else begin : g_syncPipe
        always_ff @(posedge clk) begin
          if (rstAny) pipeReg <= '0;
          else        pipeReg <= outLatch;
        end
      end
      assign dout = pipeReg;
    end else begin : g_noOutReg
      assign dout = outLatch;
    end
  endgenerate

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!gRstN)
    (!stb.acc && !rstAny) |=> (rstAny || $stable(outLatch)));

  // R10
  clear_after_rst_chk: assert property (@(posedge clk) disable iff (!gRstN)
    rstLocal |=> (outLatch == '0));

  generate
    if (MODE == WM_NORMAL) begin : g_normalChk
      // R3
      normal_hold_chk: assert property (@(posedge clk) disable iff (!gRstN)
        (stb.acc && stb.wr && !rstAny) |=> (rstAny || $stable(outLatch)));
    end
    if (MODE == WM_THROUGH) begin : g_throughChk
      // R4
      through_chk: assert property (@(posedge clk) disable iff (!gRstN)
        (stb.acc && stb.wr && !rstAny) |=> (rstAny || outLatch == $past(dinReg)));
    end
  endgenerate

endmodule

// File: rtl/bram2p_datapath.sv
module bram2p_datapath
  import bram2p_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         DATA_W    = 18,
  parameter writeMode_e MODE_A    = WM_THROUGH,
  parameter writeMode_e MODE_B    = WM_BEFORE,
  parameter bit         OUTREG_A  = 1'b0,
  parameter bit         OUTREG_B  = 1'b1,
  parameter bit         ASYNC_RST = 1'b0
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              gRstN,
  input  logic              rstA,
  input  logic              rstB,
  input  portStrobe_t       stbA,
  input  portStrobe_t       stbB,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] dinA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] dinB,
  output logic [DATA_W-1:0] doutA,
  output logic [DATA_W-1:0] doutB
);

  localparam int DEPTH = 1 << ADDR_W;

  // each bank is written by one port only; a word is bankA ^ bankB
  logic [DATA_W-1:0] bankA [DEPTH];
  logic [DATA_W-1:0] bankB [DEPTH];

  logic [ADDR_W-1:0] addrRegA, addrRegB;
  logic [DATA_W-1:0] dinRegA, dinRegB;
  logic [DATA_W-1:0] readWordA, readWordB;
  logic              aTakesWord;

  // entry registers for address and data
  always_ff @(posedge clkA) begin
    addrRegA <= addrA;
    dinRegA  <= dinA;
  end

  always_ff @(posedge clkB) begin
    addrRegB <= addrB;
    dinRegB  <= dinB;
  end

  always_comb begin
    readWordA  = bankA[addrRegA] ^ bankB[addrRegA];
    readWordB  = bankA[addrRegB] ^ bankB[addrRegB];
    aTakesWord = stbA.wr && (addrRegA == addrRegB);
  end

  always_ff @(posedge clkA) begin
    if (stbA.wr) bankA[addrRegA] <= dinRegA ^ bankB[addrRegA];
  end

  always_ff @(posedge clkB) begin
    if (stbB.wr && !aTakesWord) bankB[addrRegB] <= dinRegB ^ bankA[addrRegB];
  end

  bram2p_outstage #(
    .DATA_W(DATA_W), .MODE(MODE_A), .OUTREG(OUTREG_A), .ASYNC_RST(ASYNC_RST)
  ) u_outA (
    .clk(clkA), .gRstN(gRstN), .rstLocal(rstA), .stb(stbA),
    .dinReg(dinRegA), .readWord(readWordA), .dout(doutA)
  );

  bram2p_outstage #(
    .DATA_W(DATA_W), .MODE(MODE_B), .OUTREG(OUTREG_B), .ASYNC_RST(ASYNC_RST)
  ) u_outB (
    .clk(clkB), .gRstN(gRstN), .rstLocal(rstB), .stb(stbB),
    .dinReg(dinRegB), .readWord(readWordB), .dout(doutB)
  );

endmodule

// File: rtl/bram2p.sv
module bram2p
  import bram2p_pkg::*;
#(
  parameter int         ADDR_W    = 10,
  parameter int         DATA_W    = 18,
  parameter logic [2:0] CS_A      = 3'd0,
  parameter logic [2:0] CS_B      = 3'd0,
  parameter writeMode_e MODE_A    = WM_THROUGH,
  parameter writeMode_e MODE_B    = WM_BEFORE,
  parameter bit         OUTREG_A  = 1'b0,
  parameter bit         OUTREG_B  = 1'b1,
  parameter bit         ASYNC_RST = 1'b0
) (
  input  logic              gRstN,
  input  logic              clkA,
  input  logic              ceA,
  input  logic              weA,
  input  logic [2:0]        csA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] dinA,
  input  logic              rstA,
  output logic [DATA_W-1:0] doutA,
  input  logic              clkB,
  input  logic              ceB,
  input  logic              weB,
  input  logic [2:0]        csB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] dinB,
  input  logic              rstB,
  output logic [DATA_W-1:0] doutB
);

  portStrobe_t stbA, stbB;

  bram2p_ctrl #(.CS_SEL(CS_A)) u_ctrlA (
    .clk(clkA), .gRstN(gRstN), .ce(ceA), .we(weA), .cs(csA), .stb(stbA)
  );

  bram2p_ctrl #(.CS_SEL(CS_B)) u_ctrlB (
    .clk(clkB), .gRstN(gRstN), .ce(ceB), .we(weB), .cs(csB), .stb(stbB)
  );

  bram2p_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_A(MODE_A), .MODE_B(MODE_B),
    .OUTREG_A(OUTREG_A), .OUTREG_B(OUTREG_B), .ASYNC_RST(ASYNC_RST)
  ) u_dp (
    .clkA(clkA), .clkB(clkB), .gRstN(gRstN), .rstA(rstA), .rstB(rstB),
    .stbA(stbA), .stbB(stbB), .addrA(addrA), .dinA(dinA),
    .addrB(addrB), .dinB(dinB), .doutA(doutA), .doutB(doutB)
  );

endmodule

// File: tb/bram2p_test.sv
module bram2p_test;
  import bram2p_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        gRstN = 1'b0;
  logic        ceA = 1'b0, weA = 1'b0, rstA = 1'b0;
  logic        ceB = 1'b0, weB = 1'b0, rstB = 1'b0;
  logic [2:0]  csA = 3'd0, csB = 3'd5;
  logic [9:0]  addrA = '0, addrB = '0;
  logic [17:0] dinA = '0, dinB = '0;
  logic [17:0] doutA, doutB, altA, altB;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bram2p #(.CS_A(3'd0), .CS_B(3'd5), .MODE_A(WM_THROUGH), .MODE_B(WM_BEFORE),
           .OUTREG_A(1'b0), .OUTREG_B(1'b1), .ASYNC_RST(1'b0)) uut (
    .gRstN(gRstN), .clkA(clk), .ceA(ceA), .weA(weA), .csA(csA), .addrA(addrA),
    .dinA(dinA), .rstA(rstA), .doutA(doutA), .clkB(clk), .ceB(ceB), .weB(weB),
    .csB(csB), .addrB(addrB), .dinB(dinB), .rstB(rstB), .doutB(doutB));

  bram2p #(.CS_A(3'd0), .CS_B(3'd5), .MODE_A(WM_NORMAL), .MODE_B(WM_NORMAL),
           .OUTREG_A(1'b0), .OUTREG_B(1'b0), .ASYNC_RST(1'b1)) uutAlt (
    .gRstN(gRstN), .clkA(clk), .ceA(ceA), .weA(weA), .csA(csA), .addrA(addrA),
    .dinA(dinA), .rstA(rstA), .doutA(altA), .clkB(clk), .ceB(ceB), .weB(weB),
    .csB(csB), .addrB(addrB), .dinB(dinB), .rstB(rstB), .doutB(altB));

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle of requests; returns after the capture edge
  task automatic issue(input logic aCe, input logic aWe, input logic [9:0] aAd,
                       input logic [17:0] aD, input logic bCe, input logic bWe,
                       input logic [2:0] bCs, input logic [9:0] bAd, input logic [17:0] bD);
    @(negedge clk);
    ceA = aCe; weA = aWe; addrA = aAd; dinA = aD;
    ceB = bCe; weB = bWe; csB = bCs; addrB = bAd; dinB = bD;
    @(negedge clk);
    ceA = 1'b0; weA = 1'b0; ceB = 1'b0; weB = 1'b0; csB = 3'd5;
  endtask

  task automatic tReset();
    repeat (4) @(negedge clk);
    gRstN = 1'b1;
    check("R1 doutA", doutA, 18'h0);
    check("R1 doutB", doutB, 18'h0);
    check("R1 alt doutA", altA, 18'h0);
  endtask

  task automatic tWriteModes();
    issue(1, 1, 10'd5, 18'h01234, 0, 0, 3'd5, 0, 0);
    check("R2 A not yet", doutA, 18'h0);
    @(negedge clk);
    check("R4 write-through", doutA, 18'h01234);
    check("R3 normal holds", altA, 18'h0);
    issue(1, 0, 10'd5, 0, 0, 0, 3'd5, 0, 0);
    check("R2 alt read early", altA, 18'h0);
    @(negedge clk);
    check("R2 alt read", altA, 18'h01234);
    issue(0, 0, 0, 0, 1, 1, 3'd5, 10'd5, 18'h02222);
    @(negedge clk);
    check("R2 B outreg early", doutB, 18'h0);
    @(negedge clk);
    check("R5 read-before-write", doutB, 18'h01234);
    issue(0, 0, 0, 0, 1, 0, 3'd5, 10'd5, 0);
    @(negedge clk); @(negedge clk);
    check("R2 B read", doutB, 18'h02222);
  endtask

  task automatic tGating();
    issue(0, 0, 0, 0, 1, 1, 3'd0, 10'd5, 18'h03333);
    @(negedge clk); @(negedge clk);
    check("R7 cs mismatch holds", doutB, 18'h02222);
    issue(1, 0, 10'd5, 0, 0, 0, 3'd5, 0, 0);
    @(negedge clk);
    check("R7 cs mismatch no write", doutA, 18'h02222);
    issue(1, 1, 10'd6, 18'h00111, 0, 0, 3'd5, 0, 0);
    @(negedge clk);
    issue(0, 1, 10'd6, 18'h00999, 0, 0, 3'd5, 0, 0);
    @(negedge clk);
    check("R7 ce low holds", doutA, 18'h00111);
    issue(0, 0, 0, 0, 1, 0, 3'd5, 10'd6, 0);
    @(negedge clk); @(negedge clk);
    check("R7 ce low no write", doutB, 18'h00111);
  endtask

  task automatic tCollision();
    issue(1, 1, 10'd9, 18'h00AAA, 1, 1, 3'd5, 10'd9, 18'h00BBB);
    @(negedge clk); @(negedge clk);
    issue(0, 0, 0, 0, 1, 0, 3'd5, 10'd9, 0);
    @(negedge clk); @(negedge clk);
    check("R8 port A wins", doutB, 18'h00AAA);
    issue(1, 1, 10'd10, 18'h00010, 0, 0, 3'd5, 0, 0);
    issue(1, 1, 10'd10, 18'h00020, 1, 0, 3'd5, 10'd10, 0);
    @(negedge clk); @(negedge clk);
    check("R9 old data", doutB, 18'h00010);
    issue(0, 0, 0, 0, 1, 0, 3'd5, 10'd10, 0);
    @(negedge clk); @(negedge clk);
    check("R9 new data after", doutB, 18'h00020);
  endtask

  task automatic tBounds();
    issue(1, 1, 10'd1023, 18'h3FFFF, 0, 0, 3'd5, 0, 0);
    issue(0, 0, 0, 0, 1, 0, 3'd5, 10'd1023, 0);
    @(negedge clk); @(negedge clk);
    check("R12 top address", doutB, 18'h3FFFF);
    issue(0, 0, 0, 0, 1, 1, 3'd5, 10'd0, 18'h00001);
    issue(1, 0, 10'd0, 0, 0, 0, 3'd5, 0, 0);
    @(negedge clk);
    check("R12 address zero", doutA, 18'h00001);
    issue(0, 0, 0, 0, 1, 0, 3'd5, 10'd1023, 0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic tResets();
    @(negedge clk);
    rstA = 1'b1;
    #1;
    check("R6 async clears at once", altA, 18'h0);
    check("R6 sync waits for edge", doutA, 18'h00001);
    @(negedge clk);
    rstA = 1'b0;
    check("R10 local clears A", doutA, 18'h0);
    check("R10 B untouched", doutB, 18'h3FFFF);
    issue(1, 0, 10'd1023, 0, 0, 0, 3'd5, 0, 0);
    @(negedge clk);
    check("R11 local reset keeps array", doutA, 18'h3FFFF);
    gRstN = 1'b0;
    #1;
    check("R6 async global", altA, 18'h0);
    @(negedge clk);
    gRstN = 1'b1;
    check("R1 global A", doutA, 18'h0);
    check("R1 global B", doutB, 18'h0);
    issue(0, 0, 0, 0, 1, 0, 3'd5, 10'd9, 0);
    @(negedge clk); @(negedge clk);
    check("R11 global reset keeps array", doutB, 18'h00AAA);
  endtask

  initial begin
    tReset();
    tWriteModes();
    tGating();
    tCollision();
    tBounds();
    tResets();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule